// File: doc/BRIEF.md
# Tone-Pair Guard-Time Steering Controller

This block sits behind a dual-tone detector. It takes two inputs from the detector: a raw "tone present" level and the 4-bit code of the tone pair being heard. It only accepts a character once the tone has stayed present for a programmable accept time. It then captures the code and lets it settle for a fixed two ticks. After that it raises a delayed-valid flag, loads the code into the receive data register and, if interrupts are enabled, pulls an active-low interrupt line.

The end of a character is checked in the same way, in the other direction. The flag only clears after the tone has been absent for a separate, programmable reject time. Dropouts shorter than that leave the character in place. Both guard times are counted in ticks of a tick-enable input rather than in clock cycles. The accept and reject times are independent, so either one may be the shorter.

Reading the receive register with interrupts enabled releases the interrupt line. The flag itself stays set until the pause has been validated.

Top module: `tone_guard_steer`

## Requirements
- R1: A character is registered only after `tone_det` has been high on `accept_time`+1 consecutive ticks. A shorter burst latches nothing and leaves `dv_flag` low.
- R2: The code sampled is the value on `tone_code` at the registration tick. Later changes of `tone_code` do not alter the value that is eventually delivered.
- R3: `guard_out` is high from the registration onward while `tone_det` is high, until the pause has been validated. It is low at all other times.
- R4: `dv_flag` rises on the second tick after registration. `tone_det` is ignored during these two settling ticks.
- R5: `status` bit 0 mirrors `dv_flag`. `status` bit 1 is 1 while the interrupt output is active. Both bits are 0 after reset.
- R6: With `irq_enable` high, `irq_n` goes low in the cycle in which `dv_flag` rises. It is never low while `dv_flag` is low.
- R7: `rd_data` changes only in the cycle in which `dv_flag` rises, and it then takes the registered code. `rd_data` resets to 0.
- R8: `dv_flag` clears only after `tone_det` has been low on `reject_time`+1 consecutive ticks. Shorter dropouts leave it set.
- R9: `accept_time` and `reject_time` act independently. A value of 0 accepts the change on the first qualifying tick.
- R10: While `irq_enable` is high, a pulse on `rd_strobe` in the held state releases `irq_n`, and `dv_flag` stays set.
- R11: Cycles without `tick` do not advance either guard timer or the settling delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base enable; one guard-time unit per high cycle |
| tone_det | input | 1 | Raw tone-present level from the detector |
| tone_code | input | 4 | Code of the currently detected tone pair |
| accept_time | input | 16 | Tone-present guard time in ticks |
| reject_time | input | 16 | Tone-absent guard time in ticks |
| irq_enable | input | 1 | Enables the interrupt output |
| rd_strobe | input | 1 | One-cycle read of the receive register |
| rd_data | output | 4 | Receive data register |
| guard_out | output | 1 | Guard-active indication |
| dv_flag | output | 1 | Delayed-valid flag |
| status | output | 2 | Bit 0 delayed-valid flag, bit 1 interrupt active |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A guard counter that is off by one moves the rise or fall of `dv_flag` by one tick, which is three clock cycles here. The bench compares every output on every cycle, so the next registration or pause exposes it. A settling-delay fault shows as an early or late flag together with `rd_data` loading in the wrong cycle. A stale pending code shows as a wrong `rd_data` value as soon as the flag rises. An interrupt latch that fails to clear, or fails to set, is visible on `irq_n` and `status` bit 1 in the cycle after the read or the flag edge.

// File: rtl/tgs_pkg.sv
package tgs_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SETTLE = 2'd1,
      ST_HELD   = 2'd2
   } tgs_state_e;

   localparam int STAT_FLAG_BIT = 0;
   localparam int STAT_IRQ_BIT  = 1;
   localparam int STAT_W        = 2;
endpackage

// File: rtl/tgs_guard_timer.sv
module tgs_guard_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         run,
   input  logic         level_ok,
   input  logic [W-1:0] limit,
   output logic         fire
);
   if (W < 1) begin : g_bad_w
      $error("tgs_guard_timer: W must be at least 1");
   end

   logic [W-1:0] cnt;

   assign fire = run & level_ok & tick & (cnt >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run || !level_ok || fire) begin
         cnt <= '0;
      end else if (tick) begin
         cnt <= cnt + 1'b1;
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && run && level_ok && !fire) |-> (cnt != {W{1'b1}})); // R1
   AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run && level_ok) && run && level_ok && !$past(tick)) |-> $stable(cnt)); // R11
endmodule

// File: rtl/tgs_settle.sv
module tgs_settle #(
   parameter int TICKS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic start,
   output logic done
);
   if (TICKS < 0) begin : g_bad_ticks
      $error("tgs_settle: TICKS must not be negative");
   end

   if (TICKS == 0) begin : g_bypass
      assign done = start;
   end else begin : g_count
      localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
      localparam logic [CW-1:0] LAST = CW'(TICKS - 1);
      logic          busy;
      logic [CW-1:0] cnt;

      assign done = busy & tick & (cnt == LAST);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
         end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
         end else if (done) begin
            busy <= 1'b0;
            cnt  <= '0;
         end else if (busy && tick) begin
            cnt <= cnt + 1'b1;
         end
      end

      AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
         start |-> !busy); // R4
   end
endmodule

// File: rtl/tgs_irq.sv
module tgs_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic flag_rise,
   input  logic flag_fall,
   input  logic rd,
   output logic active
);
   logic pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
      end else if (flag_fall) begin
         pend <= 1'b0;
      end else if (flag_rise && enable) begin
         pend <= 1'b1;
      end else if (rd && enable) begin
         pend <= 1'b0;
      end
   end

   assign active = pend & enable;

   AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && enable && !flag_rise) |=> !active); // R10
endmodule

// File: rtl/tone_guard_steer.sv
module tone_guard_steer
   import tgs_pkg::*;
#(
   parameter int CODE_W       = 4,
   parameter int GUARD_W      = 16,
   parameter int SETTLE_TICKS = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                tone_det,
   input  logic [CODE_W-1:0]   tone_code,
   input  logic [GUARD_W-1:0]  accept_time,
   input  logic [GUARD_W-1:0]  reject_time,
   input  logic                irq_enable,
   input  logic                rd_strobe,
   output logic [CODE_W-1:0]   rd_data,
   output logic                guard_out,
   output logic                dv_flag,
   output logic [STAT_W-1:0]   status,
   output logic                irq_n
);
   if (CODE_W < 1) begin : g_bad_code
      $error("tone_guard_steer: CODE_W must be at least 1");
   end
   if (GUARD_W < 1) begin : g_bad_guard
      $error("tone_guard_steer: GUARD_W must be at least 1");
   end

   tgs_state_e        state;
   logic              acc_fire;
   logic              rej_fire;
   logic              settle_done;
   logic              irq_active;
   logic [CODE_W-1:0] pend_code;
   logic [CODE_W-1:0] settle_src;

   tgs_guard_timer #(.W(GUARD_W)) u_accept (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .run      (state == ST_IDLE),
      .level_ok (tone_det),
      .limit    (accept_time),
      .fire     (acc_fire)
   );

   tgs_guard_timer #(.W(GUARD_W)) u_reject (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .run      (state == ST_HELD),
      .level_ok (!tone_det),
      .limit    (reject_time),
      .fire     (rej_fire)
   );

   tgs_settle #(.TICKS(SETTLE_TICKS)) u_settle (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .start (acc_fire),
      .done  (settle_done)
   );

   tgs_irq u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (irq_enable),
      .flag_rise (settle_done),
      .flag_fall (rej_fire),
      .rd        (rd_strobe && state == ST_HELD),
      .active    (irq_active)
   );

   if (SETTLE_TICKS == 0) begin : g_direct_src
      assign settle_src = tone_code;
   end else begin : g_pend_src
      assign settle_src = pend_code;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
      end else begin
         case (state)
            ST_IDLE:   if (acc_fire) state <= settle_done ? ST_HELD : ST_SETTLE;
            ST_SETTLE: if (settle_done) state <= ST_HELD;
            ST_HELD:   if (rej_fire) state <= ST_IDLE;
            default:   state <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_code <= '0;
         rd_data   <= '0;
      end else begin
         if (acc_fire) pend_code <= tone_code;
         if (settle_done) rd_data <= settle_src;
      end
   end

   assign dv_flag   = (state == ST_HELD);
   assign guard_out = (state != ST_IDLE) && tone_det;
   assign irq_n     = !irq_active;
   always_comb begin
      status                = '0;
      status[STAT_FLAG_BIT] = dv_flag;
      status[STAT_IRQ_BIT]  = irq_active;
   end

   AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dv_flag) |-> $past(tick)); // R4
   AST_DATA_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(dv_flag) |-> $stable(rd_data)); // R7
   AST_FALL_NEEDS_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dv_flag) |-> (!$past(tone_det) && $past(tick))); // R8
   AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n |-> dv_flag); // R6
endmodule

// File: tb/tb_tone_guard_steer.sv
module tb_tone_guard_steer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        tone_det = 1'b0;
   logic [3:0]  tone_code = 4'h0;
   logic [15:0] accept_time = 16'd3;
   logic [15:0] reject_time = 16'd2;
   logic        irq_enable = 1'b0;
   logic        rd_strobe = 1'b0;
   logic [3:0]  rd_data;
   logic        guard_out;
   logic        dv_flag;
   logic [1:0]  status;
   logic        irq_n;

   int tests = 0;
   int fails = 0;
   bit done = 0;
   bit tick_gate = 1'b1;
   int div = 0;

   always #4 clk = ~clk;

   tone_guard_steer dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .tone_det(tone_det),
      .tone_code(tone_code), .accept_time(accept_time), .reject_time(reject_time),
      .irq_enable(irq_enable), .rd_strobe(rd_strobe), .rd_data(rd_data),
      .guard_out(guard_out), .dv_flag(dv_flag), .status(status), .irq_n(irq_n)
   );

   // tick every third cycle while the gate is open
   always @(negedge clk) begin
      div = (div == 2) ? 0 : div + 1;
      tick <= tick_gate && (div == 2);
   end

   // behavioural reference: phase 0 waiting, 1 settling, 2 character held
   int       m_phase = 0;
   int       m_cnt = 0;
   int       m_scnt = 0;
   bit [3:0] m_pend = 0;
   bit [3:0] m_data = 0;
   bit       m_irq = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_phase = 0; m_cnt = 0; m_scnt = 0; m_pend = 0; m_data = 0; m_irq = 0;
      end else if (m_phase == 0) begin
         if (!tone_det) m_cnt = 0;
         else if (tick) begin
            if (m_cnt >= accept_time) begin
               m_pend = tone_code; m_phase = 1; m_scnt = 0; m_cnt = 0;
            end else m_cnt++;
         end
      end else if (m_phase == 1) begin
         if (tick) begin
            if (m_scnt == 1) begin
               m_data = m_pend; m_phase = 2;
               if (irq_enable) m_irq = 1;
            end else m_scnt++;
         end
      end else begin
         if (rd_strobe && irq_enable) m_irq = 0;
         if (tone_det) m_cnt = 0;
         else if (tick) begin
            if (m_cnt >= reject_time) begin
               m_phase = 0; m_cnt = 0; m_irq = 0;
            end else m_cnt++;
         end
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R7", "rd_data", rd_data, m_data);
         check("R4", "dv_flag", dv_flag, m_phase == 2);
         check("R3", "guard_out", guard_out, (m_phase != 0) && tone_det);
         check("R6", "irq_n", irq_n, !(m_irq && irq_enable));
         check("R5", "status", status, {m_irq && irq_enable, m_phase == 2});
      end
   end

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      cycles(3);
      check("R5", "reset status", status, 0);
      check("R7", "reset rd_data", rd_data, 0);
      check("R6", "reset irq_n", irq_n, 1);
      rst_n = 1'b1;
      irq_enable = 1'b1;
      cycles(4);

      // R1: short burst (at most 3 ticks, 4 needed)
      tone_code = 4'h7; tone_det = 1'b1; cycles(8); tone_det = 1'b0; cycles(12);
      check("R1", "flag after short burst", dv_flag, 0);
      check("R1", "rd_data after short burst", rd_data, 0);

      // valid character with a short dropout, R8 and R6
      tone_code = 4'h5; tone_det = 1'b1; cycles(30);
      check("R1", "flag after full guard", dv_flag, 1);
      check("R7", "rd_data loaded", rd_data, 5);
      check("R6", "irq_n asserted", irq_n, 0);
      tone_det = 1'b0; cycles(2); tone_det = 1'b1; cycles(6);
      check("R8", "flag survives dropout", dv_flag, 1);
      rd_strobe = 1'b1; cycles(1); rd_strobe = 1'b0; cycles(1);
      check("R10", "irq released by read", irq_n, 1);
      check("R10", "flag kept after read", dv_flag, 1);
      tone_det = 1'b0; cycles(15);
      check("R8", "flag cleared after pause", dv_flag, 0);

      // R11: no ticks, nothing advances
      tick_gate = 1'b0; tone_code = 4'hB; tone_det = 1'b1; cycles(40);
      check("R11", "no registration without ticks", dv_flag, 0);
      check("R11", "guard_out without ticks", guard_out, 0);
      tick_gate = 1'b1; cycles(25);
      check("R11", "registers once ticks resume", rd_data, 11);
      tone_det = 1'b0; cycles(15);

      // R9: zero guard times, interrupts off
      accept_time = 16'd0; reject_time = 16'd0; irq_enable = 1'b0;
      tone_code = 4'h9; tone_det = 1'b1; cycles(12);
      check("R9", "zero accept registers", rd_data, 9);
      check("R6", "irq_n idle when disabled", irq_n, 1);
      tone_det = 1'b0; cycles(4);
      check("R9", "zero reject clears", dv_flag, 0);

      // R2 and R4: code changes and tone drops during settling
      accept_time = 16'd1; reject_time = 16'd4; irq_enable = 1'b1;
      tone_code = 4'hC; tone_det = 1'b1;
      while (!guard_out) @(negedge clk);
      check("R3", "guard_out at registration", guard_out, 1);
      tone_code = 4'h3; tone_det = 1'b0;
      cycles(8);
      check("R4", "flag rises despite low tone", dv_flag, 1);
      check("R2", "code from registration tick", rd_data, 12);
      check("R3", "guard_out low with tone absent", guard_out, 0);
      cycles(20);
      check("R8", "flag cleared after long pause", dv_flag, 0);

      // R9: long accept, short reject
      accept_time = 16'd10; reject_time = 16'd1;
      tone_code = 4'hA; tone_det = 1'b1; cycles(24);
      check("R9", "long accept not yet met", dv_flag, 0);
      cycles(20);
      check("R9", "long accept met", rd_data, 10);
      tone_det = 1'b0; cycles(12);
      check("R8", "short reject clears", dv_flag, 0);
      cycles(4);
      finish_run();
   end
endmodule